// File: doc/BRIEF.md
# Thermal Throttle Operating-Point Sequencer

This block lowers power when an over-temperature flag is raised, and restores it later. It works on a table of operating points. Each point pairs a core ratio code with a voltage ID code. Point 0 is the normal, unthrottled condition. Higher-numbered points have both a lower ratio and a lower voltage code, and the table is computed from parameters. Entering throttle has two phases. The core ratio jumps straight to the selected target point. The voltage ID then walks toward the target one table entry at a time, and the regulator must acknowledge each entry before the next one is issued.

Recovery starts once the flag clears and a programmable hysteresis delay runs out without the flag returning. The block then climbs back through every intermediate point. At each point the voltage is raised first and acknowledged, and only then is the ratio raised to match. If the flag comes back during the climb, the block drops the ratio straight to the target again and steps the voltage back down from where it is. Core execution is never stalled. The voltage walk happens behind a ratio that is already safe for it.

Top module: `thermal_opp_seq`

## Requirements
- R1: During and right after reset, core_ratio is the point-0 ratio, vid_code is the point-0 code, vr_busy is 0 and throttle_act is 0.
- R2: When over_temp is seen high while idle at point 0, core_ratio shows the target point's ratio one clock later, and vid_code still shows the point-0 code at that time.
- R3: Every change of vid_code moves to the code of an adjacent table entry. Each change raises vr_busy. No further change happens until vr_ack has been seen high while vr_busy was high.
- R4: A target select of 0 is treated as point 1. A target select of NPTS or more is treated as point NPTS-1.
- R5: Take the first clock edge at which the block holds its target and sees over_temp low. Counting that edge as edge 1, the first upward vid_code step appears after edge hyst_dly+3.
- R6: If over_temp is high on any edge while the hysteresis delay runs, the delay is abandoned and the block stays at the target point. This includes the edge at which the delay would have run out. The next low over_temp restarts the full delay.
- R7: While climbing, vid_code moves up one entry first. core_ratio only rises to that entry's ratio after the step is acknowledged. At no time is core_ratio above the ratio of the point whose voltage is currently applied.
- R8: If over_temp rises during the climb, core_ratio returns to the target ratio on the next clock. vid_code then steps back down to the target code.
- R9: throttle_act is 1 whenever core_ratio or vid_code is away from point 0, or while the hysteresis delay runs. It is 0 once both are back at point 0.
- R10: A vr_ack pulse while vr_busy is 0 changes neither code and does not set vr_busy.

Table encoding, with default parameters and NPTS = 6: ratio(i) = 36 - 4*i and vid(i) = 160 - 2*i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| over_temp | input | 1 | Over-temperature flag, already synchronous |
| vr_ack | input | 1 | Regulator acknowledge of the pending voltage step |
| tgt_pt | input | IDX_W | Throttle target point select (clamped, see R4) |
| hyst_dly | input | HYST_W | Hysteresis delay in clocks |
| core_ratio | output | RATIO_W | Core ratio code currently applied |
| vid_code | output | VID_W | Voltage ID code currently requested |
| vr_busy | output | 1 | A voltage step awaits acknowledge |
| throttle_act | output | 1 | Throttling or hysteresis in progress |

## Verification
Two pairs of events can fall in the same clock. The first pair is the hysteresis delay running out on the same edge where over_temp comes back. The bench forces this by raising the flag so that it is seen exactly on the expiry edge. It then checks that no upward step follows and that both codes stay at the target. The second pair is a reversal during the climb arriving while a step is still unacknowledged. The bench checks that the ratio drops on the next clock and that the pending acknowledge is consumed before any further voltage step. A background monitor checks adjacency and the ratio-versus-voltage ordering on every cycle.

// File: rtl/thermal_opp_pkg.sv
package thermal_opp_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_DOWN,
        SEQ_HOLD,
        SEQ_HYST,
        SEQ_UP
    } seq_state_e;

    // Clamp a requested throttle point into the legal range 1 .. npts-1
    function automatic int clamp_point(input int req, input int npts);
        if (req < 1)
            return 1;
        if (req > npts - 1)
            return npts - 1;
        return req;
    endfunction

    // Table entry generators: higher index means lower frequency and voltage
    function automatic int ratio_of(input int idx, input int top, input int dec);
        return top - idx * dec;
    endfunction

    function automatic int vid_of(input int idx, input int top, input int dec);
        return top - idx * dec;
    endfunction

endpackage

// File: rtl/thermal_opp_hyst.sv
module thermal_opp_hyst #(
    parameter int HYST_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [HYST_W-1:0] dly,
    output logic              done
);
    logic [HYST_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (cnt != dly)
            cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == dly);

    // R5
    cnt_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !done) |=> ((cnt == $past(cnt) + 1'b1) || (cnt == '0)));

endmodule

// File: rtl/thermal_opp_step.sv
module thermal_opp_step
    import thermal_opp_pkg::*;
#(
    parameter int NPTS  = 6,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             over_temp,
    input  logic             vr_ack,
    input  logic [IDX_W-1:0] tgt_sel,
    input  logic             hyst_done,
    output logic             in_hyst,
    output logic [IDX_W-1:0] fidx,
    output logic [IDX_W-1:0] vidx,
    output logic             busy
);
    seq_state_e       state;
    logic [IDX_W-1:0] tgt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            fidx  <= '0;
            vidx  <= '0;
            busy  <= 1'b0;
            tgt_q <= '0;
        end else begin
            if (busy && vr_ack)
                busy <= 1'b0;
            unique case (state)
                SEQ_IDLE: begin
                    if (over_temp) begin
                        tgt_q <= tgt_sel;
                        fidx  <= tgt_sel;
                        state <= SEQ_DOWN;
                    end
                end
                SEQ_DOWN: begin
                    if (!busy) begin
                        if (vidx < fidx) begin
                            vidx <= vidx + 1'b1;
                            busy <= 1'b1;
                        end else begin
                            state <= SEQ_HOLD;
                        end
                    end
                end
                SEQ_HOLD: begin
                    if (!over_temp)
                        state <= SEQ_HYST;
                end
                SEQ_HYST: begin
                    if (over_temp)
                        state <= SEQ_HOLD;
                    else if (hyst_done)
                        state <= SEQ_UP;
                end
                SEQ_UP: begin
                    if (over_temp) begin
                        fidx  <= tgt_q;
                        state <= SEQ_DOWN;
                    end else if (!busy) begin
                        if (vidx != fidx)
                            fidx <= vidx;
                        else if (fidx == '0)
                            state <= SEQ_IDLE;
                        else begin
                            vidx <= vidx - 1'b1;
                            busy <= 1'b1;
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assign in_hyst = (state == SEQ_HYST);

    // R7
    volt_covers_ratio_chk: assert property (@(posedge clk) disable iff (rst)
        vidx <= fidx);

    // R3
    vid_single_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(vidx) |-> ((vidx == $past(vidx) + 1'b1) || (vidx + 1'b1 == $past(vidx))));

    // R3
    wait_for_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !vr_ack) |=> $stable(vidx));

    // R2
    ratio_before_volt_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_IDLE && over_temp) |=> (fidx == $past(tgt_sel) && vidx == '0));

    // R6
    hyst_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_HYST && over_temp) |=> (state == SEQ_HOLD));

    // R8
    climb_reverse_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_UP && over_temp) |=> (state == SEQ_DOWN && fidx == $past(tgt_q)));

    // R10
    stray_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_HOLD && !busy && vr_ack) |=> ($stable(vidx) && !busy));

endmodule

// File: rtl/thermal_opp_map.sv
module thermal_opp_map
    import thermal_opp_pkg::*;
#(
    parameter int NPTS      = 6,
    parameter int IDX_W     = 3,
    parameter int RATIO_W   = 8,
    parameter int VID_W     = 8,
    parameter int RATIO_TOP = 36,
    parameter int RATIO_DEC = 4,
    parameter int VID_TOP   = 160,
    parameter int VID_DEC   = 2
) (
    input  logic [IDX_W-1:0]   fidx,
    input  logic [IDX_W-1:0]   vidx,
    output logic [RATIO_W-1:0] ratio,
    output logic [VID_W-1:0]   vid
);
    logic [RATIO_W-1:0] ratio_tab [NPTS];
    logic [VID_W-1:0]   vid_tab   [NPTS];

    for (genvar g = 0; g < NPTS; g++) begin : g_point
        assign ratio_tab[g] = RATIO_W'(ratio_of(g, RATIO_TOP, RATIO_DEC));
        assign vid_tab[g]   = VID_W'(vid_of(g, VID_TOP, VID_DEC));
    end

    always_comb begin
        ratio = ratio_tab[0];
        vid   = vid_tab[0];
        for (int i = 0; i < NPTS; i++) begin
            if (fidx == IDX_W'(i))
                ratio = ratio_tab[i];
            if (vidx == IDX_W'(i))
                vid = vid_tab[i];
        end
    end

endmodule

// File: rtl/thermal_opp_seq.sv
module thermal_opp_seq
    import thermal_opp_pkg::*;
#(
    parameter int NPTS      = 6,
    parameter int RATIO_W   = 8,
    parameter int VID_W     = 8,
    parameter int HYST_W    = 12,
    parameter int RATIO_TOP = 36,
    parameter int RATIO_DEC = 4,
    parameter int VID_TOP   = 160,
    parameter int VID_DEC   = 2,
    localparam int IDX_W    = $clog2(NPTS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               over_temp,
    input  logic               vr_ack,
    input  logic [IDX_W-1:0]   tgt_pt,
    input  logic [HYST_W-1:0]  hyst_dly,
    output logic [RATIO_W-1:0] core_ratio,
    output logic [VID_W-1:0]   vid_code,
    output logic               vr_busy,
    output logic               throttle_act
);
    logic [IDX_W-1:0] tgt_sel;
    logic [IDX_W-1:0] fidx;
    logic [IDX_W-1:0] vidx;
    logic             in_hyst;
    logic             hyst_done;

    // R4: legalise the target before it is captured
    assign tgt_sel = IDX_W'(clamp_point(int'(tgt_pt), NPTS));

    thermal_opp_step #(
        .NPTS  (NPTS),
        .IDX_W (IDX_W)
    ) u_step (
        .clk       (clk),
        .rst       (rst),
        .over_temp (over_temp),
        .vr_ack    (vr_ack),
        .tgt_sel   (tgt_sel),
        .hyst_done (hyst_done),
        .in_hyst   (in_hyst),
        .fidx      (fidx),
        .vidx      (vidx),
        .busy      (vr_busy)
    );

    thermal_opp_hyst #(
        .HYST_W (HYST_W)
    ) u_hyst (
        .clk  (clk),
        .rst  (rst),
        .run  (in_hyst),
        .dly  (hyst_dly),
        .done (hyst_done)
    );

    thermal_opp_map #(
        .NPTS      (NPTS),
        .IDX_W     (IDX_W),
        .RATIO_W   (RATIO_W),
        .VID_W     (VID_W),
        .RATIO_TOP (RATIO_TOP),
        .RATIO_DEC (RATIO_DEC),
        .VID_TOP   (VID_TOP),
        .VID_DEC   (VID_DEC)
    ) u_map (
        .fidx  (fidx),
        .vidx  (vidx),
        .ratio (core_ratio),
        .vid   (vid_code)
    );

    // R9
    assign throttle_act = (fidx != '0) || (vidx != '0) || in_hyst;

    // R1
    reset_point_chk: assert property (@(posedge clk)
        rst |=> (!vr_busy && !throttle_act));

endmodule

// File: tb/tb_thermal_opp_seq.sv
module tb_thermal_opp_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NPTS = 6;
    localparam int IDX_W = $clog2(NPTS);
    localparam int HYST_W = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              over_temp = 1'b0;
    logic              vr_ack = 1'b0;
    logic [IDX_W-1:0]  tgt_pt = '0;
    logic [HYST_W-1:0] hyst_dly = '0;
    logic [7:0]        core_ratio;
    logic [7:0]        vid_code;
    logic              vr_busy;
    logic              throttle_act;

    int checks = 0;
    int errors = 0;
    int mon_err = 0;
    bit auto_ack = 1'b0;
    bit done_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    thermal_opp_seq dut (
        .clk          (clk),
        .rst          (rst),
        .over_temp    (over_temp),
        .vr_ack       (vr_ack),
        .tgt_pt       (tgt_pt),
        .hyst_dly     (hyst_dly),
        .core_ratio   (core_ratio),
        .vid_code     (vid_code),
        .vr_busy      (vr_busy),
        .throttle_act (throttle_act)
    );

    function automatic int rt(input int i); return 36 - 4 * i; endfunction
    function automatic int vt(input int i); return 160 - 2 * i; endfunction
    function automatic int ridx(input int r);
        for (int i = 0; i < NPTS; i++) if (rt(i) == r) return i;
        return -1;
    endfunction
    function automatic int vidx_of(input int v);
        for (int i = 0; i < NPTS; i++) if (vt(i) == v) return i;
        return -1;
    endfunction

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Regulator model: acknowledges a pending step after a short latency
    int lat = 0;
    always @(negedge clk) begin
        if (auto_ack) begin
            if (vr_ack) vr_ack = 1'b0;
            else if (vr_busy) begin
                if (lat >= 1) begin vr_ack = 1'b1; lat = 0; end
                else lat++;
            end
        end
    end

    // Background monitor for R3 adjacency and R7 ordering
    int pv = 0;
    always @(negedge clk) begin
        if (!rst) begin
            int vi, ri;
            vi = vidx_of(int'(vid_code));
            ri = ridx(int'(core_ratio));
            if (vi < 0 || ri < 0) mon_err++;
            else begin
                if (vi != pv && vi != pv + 1 && vi != pv - 1) mon_err++;
                if (ri < vi) mon_err++;
                pv = vi;
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_vid(input int i, input string req);
        int k = 0;
        while (int'(vid_code) != vt(i) && k < 400) begin @(negedge clk); k++; end
        chk(req, int'(vid_code), vt(i), "vid reached");
    endtask

    task automatic wait_idle(input string req);
        int k = 0;
        while (throttle_act && k < 600) begin @(negedge clk); k++; end
        chk(req, int'(throttle_act), 0, "throttle_act back low");
        cyc(2);
    endtask

    // Drops over_temp at this negedge and counts edges to the first vid change
    task automatic measure(output int n);
        int v0 = int'(vid_code);
        over_temp = 1'b0;
        n = 0;
        while (int'(vid_code) == v0 && n < 2000) begin @(negedge clk); n++; end
    endtask

    task automatic go_hold(input int t);
        tgt_pt = IDX_W'(t);
        over_temp = 1'b1;
        auto_ack = 1'b1;
        wait_vid(t, "R3");
        while (vr_busy) @(negedge clk);
        cyc(3);
    endtask

    task automatic t_reset();
        cyc(1);
        chk("R1", int'(core_ratio), rt(0), "ratio in reset");
        chk("R1", int'(vid_code), vt(0), "vid in reset");
        rst = 1'b0;
        cyc(1);
        chk("R1", int'(vr_busy), 0, "busy after reset");
        chk("R9", int'(throttle_act), 0, "throttle_act after reset");
    endtask

    task automatic t_down_manual();
        auto_ack = 1'b0;
        tgt_pt = 3;
        over_temp = 1'b1;
        cyc(1);
        chk("R2", int'(core_ratio), rt(3), "ratio first");
        chk("R2", int'(vid_code), vt(0), "vid unchanged with ratio");
        chk("R9", int'(throttle_act), 1, "throttle_act on entry");
        cyc(1);
        chk("R3", int'(vid_code), vt(1), "first down step");
        chk("R3", int'(vr_busy), 1, "busy with step");
        cyc(4);
        chk("R3", int'(vid_code), vt(1), "no step without ack");
        vr_ack = 1'b1; cyc(1); vr_ack = 1'b0;
        chk("R3", int'(vr_busy), 0, "ack clears busy");
        cyc(1);
        chk("R3", int'(vid_code), vt(2), "second step after ack");
        go_hold(3);
        chk("R2", int'(core_ratio), rt(3), "ratio at target");
    endtask

    task automatic t_stray_ack();
        auto_ack = 1'b0;
        vr_ack = 1'b1; cyc(1); vr_ack = 1'b0;
        cyc(2);
        chk("R10", int'(vid_code), vt(3), "vid after stray ack");
        chk("R10", int'(core_ratio), rt(3), "ratio after stray ack");
        chk("R10", int'(vr_busy), 0, "busy after stray ack");
        auto_ack = 1'b1;
    endtask

    task automatic t_hyst_return();
        int n;
        hyst_dly = 5;
        measure(n);
        chk("R5", n, 5 + 3, "edges to first up step");
        chk("R7", int'(vid_code), vt(2), "voltage rises first");
        chk("R7", int'(core_ratio), rt(3), "ratio waits for ack");
        wait_idle("R9");
        chk("R7", int'(core_ratio), rt(0), "ratio restored");
        chk("R7", int'(vid_code), vt(0), "vid restored");
    endtask

    task automatic t_hyst_abort();
        int n;
        go_hold(3);
        hyst_dly = 10;
        over_temp = 1'b0;
        cyc(6);
        chk("R9", int'(throttle_act), 1, "active during hysteresis");
        over_temp = 1'b1; cyc(1);
        measure(n);
        chk("R6", n, 10 + 3, "full delay restarts");
        wait_idle("R6");
        // Flag returns on the very edge the delay would expire
        go_hold(3);
        hyst_dly = 4;
        over_temp = 1'b0;
        cyc(5);
        over_temp = 1'b1;
        cyc(6);
        chk("R6", int'(vid_code), vt(3), "vid held at expiry collision");
        chk("R6", int'(core_ratio), rt(3), "ratio held at expiry collision");
        over_temp = 1'b0;
        wait_idle("R6");
    endtask

    task automatic t_clamp();
        hyst_dly = 2;
        tgt_pt = 0;
        over_temp = 1'b1;
        cyc(1);
        chk("R4", int'(core_ratio), rt(1), "target 0 clamped to 1");
        cyc(6);
        over_temp = 1'b0;
        wait_idle("R4");
        tgt_pt = 7;
        over_temp = 1'b1;
        cyc(1);
        chk("R4", int'(core_ratio), rt(NPTS - 1), "large target clamped");
        wait_vid(NPTS - 1, "R4");
        over_temp = 1'b0;
        wait_idle("R4");
    endtask

    task automatic t_reverse();
        go_hold(4);
        hyst_dly = 0;
        over_temp = 1'b0;
        wait_vid(2, "R8");
        over_temp = 1'b1;
        cyc(1);
        chk("R8", int'(core_ratio), rt(4), "ratio back to target");
        wait_vid(4, "R8");
        while (vr_busy) @(negedge clk);
        cyc(3);
        chk("R8", int'(vid_code), vt(4), "vid settled at target");
        chk("R8", int'(core_ratio), rt(4), "ratio settled at target");
        over_temp = 1'b0;
        wait_idle("R8");
    endtask

    initial begin
        cyc(3);
        t_reset();
        t_down_manual();
        t_stray_ack();
        t_hyst_return();
        t_hyst_abort();
        t_clamp();
        t_reverse();
        chk("R3", mon_err, 0, "monitor adjacency and R7 ordering errors");
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

endmodule